// File: doc/BRIEF.md
# PLL Phase Alignment Calibrator

This block brings the reference and feedback clocks of several PLLs into phase, calibrating all of them at the same time. Every PLL has two delay lines, each set by a 5-bit code: one on the reference path and one on the feedback path. For each PLL the block keeps a calibration lane that holds a direction and a delay code. From these it drives the two delay fields.

The block repeats a fixed loop:
- Apply the delay fields and hold them for a settle interval.
- Switch on the sampling phase detectors, which report a single bit per PLL per clock.
- Count ones and zeros over a window of samples.
- Step every lane that is not yet finished.

The first measurement decides a lane's direction: either the reference lags or the reference leads. After that decision only one path of that PLL is delayed. A lane whose counts balance within a threshold stops by itself, and the other lanes keep iterating. The run succeeds when every lane has stopped. It aborts with a fail flag as soon as any lane's delay code reaches 32.

Top module: `pcal_phase_align`

## Requirements
- R1: After reset `busy`, `fail`, `meter_en`, every `lane_done` bit and every delay field are 0. A `cal_start` pulse returns all lanes to the initial direction with code 0 and not done, clears `fail`, and raises `busy` on the next clock edge.
- R2: Lane l drives `ref_dly[5l+4:5l]` and `fb_dly[5l+4:5l]`:
  - In the initial direction both fields are 0.
  - In the reference-lags direction `fb_dly` carries the lane code and `ref_dly` is 0.
  - In the reference-leads direction `ref_dly` carries the code and `fb_dly` is 0.
  - The two fields of a lane are never both non-zero.
- R3: In each measurement `meter_en` is high for exactly MEAS_CYC consecutive cycles. Each lane counts ones and zeros of `det_sample[l]` over only the first WINDOW of those cycles. Samples after the window do not change the result.
- R4: In the initial direction, with D = ones − zeros as a signed number:
  - If D > THRESH the lane switches to reference-lags and its code becomes 1.
  - Otherwise, if −D > THRESH, it switches to reference-leads and its code becomes 1.
  - Otherwise it is done with both fields 0.
- R5: In reference-lags a lane is done when ones − zeros ≤ THRESH, and otherwise increments its code. Reference-leads uses zeros − ones in the same way. A done lane keeps its bit and its fields until the next `cal_start`, while the other lanes continue.
- R6: Between two measurements `meter_en` is low for exactly SETTLE_CYC+2 cycles. The delay fields do not change while `meter_en` is high.
- R7: When every lane is done, `busy` falls with `fail` = 0.
- R8: When a lane's code reaches 32 without all lanes done, `busy` falls with `fail` = 1, and not all `lane_done` bits are set.
- R9: A `cal_start` pulse during a run abandons the run and restarts calibration from R1's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | One-cycle pulse that starts or restarts calibration |
| det_sample | input | LANES | Phase detector sample per lane (1 = reference behind feedback) |
| meter_en | output | 1 | Phase detectors enabled (measurement window running) |
| ref_dly | output | LANES*DW | Reference-path delay code per lane |
| fb_dly | output | LANES*DW | Feedback-path delay code per lane |
| lane_done | output | LANES | Lane has converged |
| busy | output | 1 | Calibration in progress |
| fail | output | 1 | Last run aborted on delay overflow |

## Verification
A wrong direction decision shows up right after the first measurement. The wrong field of the lane starts to rise, or a lane meant to stop keeps stepping. Either way the run ends with a final code other than the skew minus one, or on the fail flag.

A miscounted window or a stale counter skews every later decision. The bench catches this by driving ones after the window closes and by sweeping skews across both signs up to the overflow edge. Its model delays the detector response by the applied codes, so each run's final fields are a closed-form function of the skew.

A restart that fails to clear a lane leaves it on the old direction. That lane then overflows instead of converging.

// File: rtl/pcal_pkg.sv
// Shared types for the phase alignment calibrator.
package pcal_pkg;
    // Width of each detector count (ones / zeros halves of a result word).
    localparam int CNT_W = 16;

    // Direction a lane has committed to.
    typedef enum logic [1:0] {
        DIR_INIT = 2'd0,
        DIR_LAG  = 2'd1,   // reference lags: delay the feedback path
        DIR_LEAD = 2'd2    // reference leads: delay the reference path
    } lane_dir_e;

    // Iteration sequencer states.
    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_SETTLE = 3'd1,
        SQ_MEAS   = 3'd2,
        SQ_EVAL   = 3'd3,
        SQ_CHECK  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/pcal_meter.sv
// Sampling jitter meter for one lane.
// Counts ones and zeros of the detector sample over the first WINDOW
// enabled cycles after a clear. Holds the counts until the next clear.
// Assumes WINDOW fits in CNT_W bits.
module pcal_meter #(
    parameter int WINDOW = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       en,
    input  logic                       sample,
    output logic [pcal_pkg::CNT_W-1:0] ones,
    output logic [pcal_pkg::CNT_W-1:0] zeros
);
    localparam int TW = $clog2(WINDOW + 1);

    logic [TW-1:0] taken;

    // Clear on request, otherwise accumulate until the window is full.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            taken <= '0;
            ones  <= '0;
            zeros <= '0;
        end else if (en && (taken < TW'(WINDOW))) begin
            taken <= taken + 1'b1;
            if (sample) ones  <= ones + 1'b1;
            else        zeros <= zeros + 1'b1;
        end
    end
endmodule

// File: rtl/pcal_lane.sv
// Calibration state of one PLL.
// Holds the direction, the delay code (one bit wider than the delay field,
// so that reaching 2**DW is visible) and the done flag.
// Steps once per eval pulse while not done. Differences are signed, so a
// negative difference never exceeds the threshold.
module pcal_lane #(
    parameter int DW     = 5,
    parameter int THRESH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       restart,
    input  logic                       eval,
    input  logic [pcal_pkg::CNT_W-1:0] ones,
    input  logic [pcal_pkg::CNT_W-1:0] zeros,
    output logic                       done,
    output logic                       ovf,
    output logic [DW-1:0]              ref_dly,
    output logic [DW-1:0]              fb_dly
);
    import pcal_pkg::*;

    localparam int SW = CNT_W + 1;
    localparam logic signed [SW-1:0] TH = SW'(THRESH);

    lane_dir_e         dir;
    logic [DW:0]       code;
    logic signed [SW-1:0] lag_diff;
    logic signed [SW-1:0] lead_diff;

    // Signed count differences for both directions.
    always_comb begin
        lag_diff  = signed'({1'b0, ones})  - signed'({1'b0, zeros});
        lead_diff = signed'({1'b0, zeros}) - signed'({1'b0, ones});
    end

    // Direction decision and delay stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            dir  <= DIR_INIT;
            code <= '0;
            done <= 1'b0;
        end else if (eval && !done) begin
            unique case (dir)
                DIR_INIT: begin
                    if (lag_diff > TH) begin
                        dir  <= DIR_LAG;
                        code <= code + 1'b1;
                    end else if (lead_diff > TH) begin
                        dir  <= DIR_LEAD;
                        code <= code + 1'b1;
                    end else begin
                        done <= 1'b1;
                    end
                end
                DIR_LAG: begin
                    if (lag_diff <= TH) done <= 1'b1;
                    else                code <= code + 1'b1;
                end
                DIR_LEAD: begin
                    if (lead_diff <= TH) done <= 1'b1;
                    else                 code <= code + 1'b1;
                end
                default: dir <= DIR_INIT;
            endcase
        end
    end

    // Route the code to the path selected by the direction.
    always_comb begin
        ovf     = code[DW];
        ref_dly = (dir == DIR_LEAD) ? code[DW-1:0] : '0;
        fb_dly  = (dir == DIR_LAG)  ? code[DW-1:0] : '0;
    end
endmodule

// File: rtl/pcal_seq.sv
// Iteration sequencer shared by all lanes.
// Loop: settle (meters cleared, off) -> measure -> evaluate -> check.
// Check ends the run on all-done (success) or on any overflow (fail).
// Assumes MEAS_CYC >= WINDOW of the meters and SETTLE_CYC >= 1.
module pcal_seq #(
    parameter int SETTLE_CYC = 2000,
    parameter int MEAS_CYC   = 1100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic all_done,
    input  logic any_ovf,
    output logic busy,
    output logic meter_en,
    output logic meter_clr,
    output logic eval,
    output logic fail
);
    import pcal_pkg::*;

    localparam int MAXC = (SETTLE_CYC > MEAS_CYC) ? SETTLE_CYC : MEAS_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;

    // State and interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            fail  <= 1'b0;
        end else if (start) begin
            state <= SQ_SETTLE;
            cnt   <= '0;
            fail  <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: cnt <= '0;
                SQ_SETTLE: begin
                    if (cnt == CW'(SETTLE_CYC - 1)) begin
                        state <= SQ_MEAS;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_MEAS: begin
                    if (cnt == CW'(MEAS_CYC - 1)) begin
                        state <= SQ_EVAL;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_EVAL: state <= SQ_CHECK;
                SQ_CHECK: begin
                    if (all_done) begin
                        state <= SQ_IDLE;
                    end else if (any_ovf) begin
                        state <= SQ_IDLE;
                        fail  <= 1'b1;
                    end else begin
                        state <= SQ_SETTLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Decoded controls.
    always_comb begin
        busy      = (state != SQ_IDLE);
        meter_en  = (state == SQ_MEAS);
        meter_clr = (state == SQ_SETTLE);
        eval      = (state == SQ_EVAL);
    end
endmodule

// File: rtl/pcal_phase_align.sv
// PLL phase alignment calibrator, top level.
// One meter and one lane per PLL, all stepped by a shared sequencer.
// Assumes det_sample is synchronous to clk and MEAS_CYC >= WINDOW.
module pcal_phase_align #(
    parameter int LANES      = 3,
    parameter int DW         = 5,
    parameter int WINDOW     = 1024,
    parameter int THRESH     = 16,
    parameter int SETTLE_CYC = 2000,
    parameter int MEAS_CYC   = 1100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cal_start,
    input  logic [LANES-1:0]      det_sample,
    output logic                  meter_en,
    output logic [LANES*DW-1:0]   ref_dly,
    output logic [LANES*DW-1:0]   fb_dly,
    output logic [LANES-1:0]      lane_done,
    output logic                  busy,
    output logic                  fail
);
    import pcal_pkg::*;

    logic             meter_clr;
    logic             eval;
    logic [LANES-1:0] ovf;

    pcal_seq #(
        .SETTLE_CYC(SETTLE_CYC),
        .MEAS_CYC  (MEAS_CYC)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cal_start),
        .all_done (&lane_done),
        .any_ovf  (|ovf),
        .busy     (busy),
        .meter_en (meter_en),
        .meter_clr(meter_clr),
        .eval     (eval),
        .fail     (fail)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [CNT_W-1:0] ones;
        logic [CNT_W-1:0] zeros;

        pcal_meter #(.WINDOW(WINDOW)) meter_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (meter_clr),
            .en    (meter_en),
            .sample(det_sample[l]),
            .ones  (ones),
            .zeros (zeros)
        );

        pcal_lane #(.DW(DW), .THRESH(THRESH)) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .restart(cal_start),
            .eval   (eval),
            .ones   (ones),
            .zeros  (zeros),
            .done   (lane_done[l]),
            .ovf    (ovf[l]),
            .ref_dly(ref_dly[l*DW +: DW]),
            .fb_dly (fb_dly[l*DW +: DW])
        );
    end
endmodule

// File: rtl/pcal_phase_align_chk.sv
// Port-level checker for pcal_phase_align, bound to every instance.
module pcal_phase_align_chk #(
    parameter int LANES = 3,
    parameter int DW    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cal_start,
    input logic                meter_en,
    input logic [LANES*DW-1:0] ref_dly,
    input logic [LANES*DW-1:0] fb_dly,
    input logic [LANES-1:0]    lane_done,
    input logic                busy,
    input logic                fail
);
    // Delay fields must hold still for the whole measurement (R6).
    p_stable_meas_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (meter_en && $past(meter_en)) |-> ($stable(ref_dly) && $stable(fb_dly)));

    // Done bits only drop through a start pulse (R5).
    p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_start |=> ((lane_done & $past(lane_done)) == $past(lane_done)));

    // A failed run never has every lane done (R8).
    p_fail_notall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !(&lane_done));

    // Start raises busy on the next edge (R1).
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> (busy && !fail && (lane_done == '0)));

    // Detectors only run while busy (R6).
    p_meter_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        meter_en |-> busy);

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // Only one path of a lane is delayed (R2).
        p_one_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !((ref_dly[l*DW +: DW] != '0) && (fb_dly[l*DW +: DW] != '0)));

        // A finished lane keeps its fields (R5).
        p_done_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_done[l] && $past(lane_done[l])) |->
                ($stable(ref_dly[l*DW +: DW]) && $stable(fb_dly[l*DW +: DW])));
    end
endmodule

bind pcal_phase_align pcal_phase_align_chk #(.LANES(LANES), .DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_start(cal_start),
    .meter_en (meter_en),
    .ref_dly  (ref_dly),
    .fb_dly   (fb_dly),
    .lane_done(lane_done),
    .busy     (busy),
    .fail     (fail)
);

// File: tb/pcal_phase_align_tb_top.sv
// Bench: a detector model whose ones-count moves with the applied delays,
// swept over skews of both signs up to the overflow edge.
module pcal_phase_align_tb_top;
    localparam int LANES  = 3;
    localparam int DW     = 5;
    localparam int WINDOW = 32;
    localparam int THRESH = 4;
    localparam int SETTLE = 4;
    localparam int MEAS   = 40;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cal_start = 1'b0;
    logic [LANES-1:0]    det_sample = '0;
    logic                meter_en;
    logic [LANES*DW-1:0] ref_dly;
    logic [LANES*DW-1:0] fb_dly;
    logic [LANES-1:0]    lane_done;
    logic                busy;
    logic                fail;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int skew [LANES];
    bit tail_ones = 1'b0;
    int idx = 0;

    always #2 clk = ~clk;   // 250 MHz

    pcal_phase_align #(
        .LANES(LANES), .DW(DW), .WINDOW(WINDOW), .THRESH(THRESH),
        .SETTLE_CYC(SETTLE), .MEAS_CYC(MEAS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
        .det_sample(det_sample), .meter_en(meter_en),
        .ref_dly(ref_dly), .fb_dly(fb_dly), .lane_done(lane_done),
        .busy(busy), .fail(fail)
    );

    // Detector model: phase error e = skew - fb + ref; ones = W/2 + 2e.
    always @(negedge clk) begin
        if (meter_en) begin
            for (int l = 0; l < LANES; l++) begin
                int e, tgt;
                e   = skew[l] - int'(fb_dly[l*DW +: DW]) + int'(ref_dly[l*DW +: DW]);
                tgt = WINDOW / 2 + 2 * e;
                if (tgt < 0) tgt = 0;
                if (tgt > WINDOW) tgt = WINDOW;
                det_sample[l] <= (idx >= WINDOW) ? tail_ones : (idx < tgt);
            end
            idx <= idx + 1;
        end else begin
            det_sample <= '0;
            idx <= 0;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) cal_start = 1'b1;
        @(negedge clk) cal_start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check("R7/R8 run ends", int'(busy), 0);
    endtask

    // Expected outcome per requirement arithmetic (R4, R5, R8).
    task automatic run_and_check(input int s0, input int s1, input int s2);
        int s [LANES];
        bit exp_fail;
        s[0] = s0; s[1] = s1; s[2] = s2;
        for (int l = 0; l < LANES; l++) skew[l] = s[l];
        pulse_start();
        check("R1 busy after start", int'(busy), 1);
        wait_idle();
        exp_fail = 1'b0;
        for (int l = 0; l < LANES; l++)
            if (s[l] > 32 || s[l] < -32) exp_fail = 1'b1;
        check("R8 fail flag", int'(fail), int'(exp_fail));
        if (!exp_fail) begin
            check("R7 all done", int'(lane_done), (1 << LANES) - 1);
            for (int l = 0; l < LANES; l++) begin
                int er, ef;
                er = (s[l] < -1) ? (-s[l] - 1) : 0;
                ef = (s[l] > 1)  ? (s[l] - 1)  : 0;
                check("R5 ref code", int'(ref_dly[l*DW +: DW]), er);
                check("R5 fb code",  int'(fb_dly[l*DW +: DW]),  ef);
            end
        end
    endtask

    initial begin
        for (int l = 0; l < LANES; l++) skew[l] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 fail", int'(fail), 0);
        check("R1 done", int'(lane_done), 0);
        check("R1 ref", int'(ref_dly), 0);
        check("R1 fb", int'(fb_dly), 0);
        check("R1 meter", int'(meter_en), 0);

        // R2 initial fields zero and R6 settle first, right after start
        skew[0] = 20; skew[1] = -20; skew[2] = 0;
        pulse_start();
        check("R2 init ref", int'(ref_dly), 0);
        check("R2 init fb", int'(fb_dly), 0);
        check("R6 settle first", int'(meter_en), 0);
        // R3/R6 measure the enable pattern
        begin
            int hi = 0, lo = 0, n = 0;
            while (!meter_en && n < 500) begin @(negedge clk); n++; end
            while (meter_en) begin hi++; @(negedge clk); end
            while (!meter_en && lo < 500) begin lo++; @(negedge clk); end
            check("R3 measure length", hi, MEAS);
            check("R6 gap length", lo, SETTLE + 2);
            // R2 directions after first step
            check("R2 lag uses fb", int'(fb_dly[0 +: DW] != 0), 1);
            check("R2 lag ref zero", int'(ref_dly[0 +: DW]), 0);
            check("R2 lead uses ref", int'(ref_dly[DW +: DW] != 0), 1);
            check("R2 lead fb zero", int'(fb_dly[DW +: DW]), 0);
            check("R4 balanced lane done", int'(lane_done[2]), 1);
        end
        // R9 restart mid-run with lane 0 reversed
        repeat (200) @(negedge clk);
        skew[0] = -10; skew[1] = 3; skew[2] = 1;
        pulse_start();
        check("R9 restart clears done", int'(lane_done), 0);
        wait_idle();
        check("R9 restart fail", int'(fail), 0);
        check("R9 restart ref0", int'(ref_dly[0 +: DW]), 9);
        check("R9 restart fb0", int'(fb_dly[0 +: DW]), 0);
        check("R9 restart fb1", int'(fb_dly[DW +: DW]), 2);

        // R3 samples after the window are ignored
        tail_ones = 1'b1;
        run_and_check(0, 0, -1);
        tail_ones = 1'b0;

        // R4/R5/R8 sweep across signs and the overflow edge
        for (int s = -34; s <= 34; s++)
            run_and_check(s, -(s / 2), ((s * 7) % 23) - 11);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule